// File: doc/BRIEF.md
# Time-of-Day Counter with Selectable Encoding and Hour Format

This block keeps the time of day as three bytes: seconds, minutes and hours. A one-hertz tick advances them by one second, and carries move from seconds into minutes and from minutes into hours. A small synchronous host port reads and writes the three time bytes and one control byte. The control byte holds three mode bits: a freeze bit, an encoding bit and an hour-format bit. The encoding bit picks plain binary or packed BCD. The hour-format bit picks 24-hour or 12-hour counting. In 12-hour mode, bit 7 of the hours byte is the PM flag.

To load a new time, the host sets the freeze bit, writes the bytes and clears the freeze bit. While the freeze bit is set, no tick can change the counters partway through the load. Ticks that arrive while the block is frozen are discarded, not saved for later. Each completed advance produces a single-cycle done strobe. Changing a mode bit does not convert the stored bytes, so the host reloads the time after it changes a mode bit.

Top module: `rtc_time_keeper`

## Requirements
- R1: When the freeze bit (control bit 0) is 0, a clock cycle with `tick_i` high and no host write to a time byte advances the time by exactly one second. The new value is readable from the following cycle.
- R2: Seconds and minutes roll over from 59 to 0 and carry one into the next field.
- R3: When the hour-format bit (control bit 2) is 1, the hours run from 0 to 23 and roll over from 23 to 0.
- R4: When the hour-format bit is 0, bits 6:0 of the hours byte count 12, 1, 2, …, 11, and bit 7 is the PM flag. The PM flag inverts on the step from 11 to 12 and on no other step.
- R5: When the encoding bit (control bit 1) is 1, the bytes count in plain binary. When it is 0, they count in packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R6: When the freeze bit is 1, a tick changes nothing and produces no done strobe. Clearing the freeze bit afterwards does not replay any tick that was dropped.
- R7: A host write stores its byte exactly as written. The seconds byte is at address 0, minutes at 2, hours at 4 and control at 8. `rdata_o` returns the byte selected by `addr_i` in the same cycle, and any other address reads as 0. The control byte reads back in bits 2:0 with bits 7:3 at 0.
- R8: Reset clears the three time bytes and the done strobe, and leaves the control byte unchanged.
- R9: A tick in the same cycle as a host write to a time byte is dropped. The write takes effect and no done strobe follows.
- R10: `upd_done_o` is high for exactly one cycle after each accepted tick. That cycle is the first cycle in which the new time is readable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-hertz advance request, one cycle wide |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | ADDR_W (4) | Host byte address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Byte at `addr_i`, combinational |
| upd_done_o | output | 1 | Single-cycle strobe after each completed advance |

## Verification
On every cycle, the bound assertions check the following. A frozen tick gives no strobe and leaves the time bytes unchanged. Every strobe follows an accepted tick, and every accepted tick gives a strobe. A write collision suppresses the strobe. Each strobe comes with a changed seconds byte. The counting itself is shown only by the bench's scenarios: the carry chain, the rollover points, the BCD digit steps and the 12-hour sequence with its PM flip. The bench also shows that reset leaves the control byte alone and that dropped ticks are not replayed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int CTRL_FREEZE = 0;
    localparam int CTRL_BIN    = 1;
    localparam int CTRL_H24    = 2;
    localparam int CTRL_W      = 3;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic       done;
    } rtc_state_t;

    // constant value in the selected encoding
    function automatic logic [7:0] enc_num(int unsigned n, logic bin);
        if (bin) return 8'(n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    // add one in the selected encoding
    function automatic logic [7:0] step_val(logic [7:0] v, logic bin);
        if (bin) return v + 8'd1;
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_field_inc.sv
module rtc_field_inc
    import rtc_pkg::*;
#(
    parameter int MAX_VAL = 59
) (
    input  logic [7:0] val_i,
    input  logic       bin_i,
    output logic [7:0] next_o,
    output logic       wrap_o
);
    localparam logic [7:0] LIM_BIN = enc_num(MAX_VAL, 1'b1);
    localparam logic [7:0] LIM_BCD = enc_num(MAX_VAL, 1'b0);

    logic [7:0] lim;

    always_comb begin
        lim    = bin_i ? LIM_BIN : LIM_BCD;
        wrap_o = (val_i >= lim);
        next_o = wrap_o ? 8'd0 : step_val(val_i, bin_i);
    end
endmodule

// File: rtl/rtc_hour_inc.sv
module rtc_hour_inc
    import rtc_pkg::*;
(
    input  logic [7:0] val_i,
    input  logic       bin_i,
    input  logic       h24_i,
    output logic [7:0] next_o
);
    logic [7:0] top24;
    logic [6:0] h12;
    logic       pm;
    logic [6:0] e12;
    logic [6:0] e11;
    logic [6:0] e1;
    logic [7:0] h12_step;

    always_comb begin
        top24    = enc_num(23, bin_i);
        e12      = 7'(enc_num(12, bin_i));
        e11      = 7'(enc_num(11, bin_i));
        e1       = 7'(enc_num(1, bin_i));
        pm       = val_i[7];
        h12      = val_i[6:0];
        h12_step = step_val({1'b0, h12}, bin_i);
        if (h24_i) begin
            next_o = (val_i >= top24) ? 8'd0 : step_val(val_i, bin_i);
        end else if (h12 >= e12) begin
            next_o = {pm, e1};
        end else if (h12 == e11) begin
            next_o = {~pm, e12};
        end else begin
            next_o = {pm, h12_step[6:0]};
        end
    end
endmodule

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int SEC_ADDR  = 0,
    parameter int MIN_ADDR  = 2,
    parameter int HOUR_ADDR = 4,
    parameter int CTRL_ADDR = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              upd_done_o
);
    localparam int NUM_FLD = 2;
    localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(SEC_ADDR);
    localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(MIN_ADDR);
    localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(HOUR_ADDR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

    rtc_state_t          state_d, state_q;
    logic [CTRL_W-1:0]   ctrl_d, ctrl_q;

    logic [NUM_FLD-1:0][7:0] fld_val;
    logic [NUM_FLD-1:0][7:0] fld_next;
    logic [NUM_FLD-1:0]      fld_wrap;
    logic [7:0]              hour_next;

    logic sec_w, min_w, hour_w, ctrl_w_en;
    logic time_wr, advance;
    logic [7:0] sec_q_w, min_q_w, hour_q_w;
    logic       freeze_w;

    assign fld_val[0] = state_q.sec;
    assign fld_val[1] = state_q.min;

    generate
        for (genvar gi = 0; gi < NUM_FLD; gi++) begin : g_fld
            rtc_field_inc #(.MAX_VAL(59)) u_fld (
                .val_i  (fld_val[gi]),
                .bin_i  (ctrl_q[CTRL_BIN]),
                .next_o (fld_next[gi]),
                .wrap_o (fld_wrap[gi])
            );
        end
    endgenerate

    rtc_hour_inc u_hour (
        .val_i  (state_q.hour),
        .bin_i  (ctrl_q[CTRL_BIN]),
        .h24_i  (ctrl_q[CTRL_H24]),
        .next_o (hour_next)
    );

    always_comb begin
        sec_w     = wr_en_i && (addr_i == A_SEC);
        min_w     = wr_en_i && (addr_i == A_MIN);
        hour_w    = wr_en_i && (addr_i == A_HOUR);
        ctrl_w_en = wr_en_i && (addr_i == A_CTRL);
        time_wr   = sec_w || min_w || hour_w;
        advance   = tick_i && !ctrl_q[CTRL_FREEZE] && !time_wr;

        state_d      = state_q;
        state_d.done = advance;
        ctrl_d       = ctrl_q;

        if (advance) begin
            state_d.sec = fld_next[0];
            if (fld_wrap[0]) begin
                state_d.min = fld_next[1];
                if (fld_wrap[1]) begin
                    state_d.hour = hour_next;
                end
            end
        end

        if (sec_w)     state_d.sec  = wdata_i;
        if (min_w)     state_d.min  = wdata_i;
        if (hour_w)    state_d.hour = wdata_i;
        if (ctrl_w_en) ctrl_d       = wdata_i[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // mode bits survive reset by design
    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    assign sec_q_w  = state_q.sec;
    assign min_q_w  = state_q.min;
    assign hour_q_w = state_q.hour;
    assign freeze_w = ctrl_q[CTRL_FREEZE];

    always_comb begin
        unique case (addr_i)
            A_SEC:   rdata_o = sec_q_w;
            A_MIN:   rdata_o = min_q_w;
            A_HOUR:  rdata_o = hour_q_w;
            A_CTRL:  rdata_o = {{(8-CTRL_W){1'b0}}, ctrl_q};
            default: rdata_o = 8'd0;
        endcase
    end

    assign upd_done_o = state_q.done;

endmodule

// File: rtl/rtc_time_keeper_chk.sv
module rtc_time_keeper_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              freeze,
    input logic [7:0]        sec,
    input logic [7:0]        min,
    input logic [7:0]        hour,
    input logic              done
);
    logic time_addr;
    assign time_addr = (addr_i == ADDR_W'(0)) || (addr_i == ADDR_W'(2)) ||
                       (addr_i == ADDR_W'(4));

    a_r6_frozen_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && tick_i) |=> !done);

    a_r6_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !wr_en_i) |=> ($stable(sec) && $stable(min) && $stable(hour)));

    a_r1_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(tick_i) && !$past(freeze)));

    a_r1_tick_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !freeze && !wr_en_i) |=> done);

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && wr_en_i && time_addr) |=> !done);

    a_r10_done_new_time: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sec != $past(sec)));

endmodule

bind rtc_time_keeper rtc_time_keeper_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .freeze  (freeze_w),
    .sec     (sec_q_w),
    .min     (min_q_w),
    .hour    (hour_q_w),
    .done    (upd_done_o)
);

// File: tb/rtc_time_keeper_bench.sv
`timescale 1ns/1ps
module rtc_time_keeper_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] addr_i = 4'd0;
    logic [7:0] wdata_i = 8'd0;
    logic [7:0] rdata_o;
    logic       upd_done_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int m_s = 0, m_m = 0, m_h = 0;
    bit m_bin = 0, m_h24 = 0, m_frz = 0;

    always #4 clk = ~clk;

    rtc_time_keeper u_rtc_time_keeper (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .upd_done_o(upd_done_o)
    );

    function automatic logic [7:0] enc(int v, bit bin);
        if (bin) return 8'(v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic logic [7:0] hour_byte(int h, bit bin, bit h24);
        int h12;
        if (h24) return enc(h, bin);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return {(h >= 12) ? 1'b1 : 1'b0, enc(h12, bin)[6:0]};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr_i = a;
        #0.2;
        d = rdata_o;
    endtask

    task automatic check_time(string req);
        logic [7:0] d;
        logic [7:0] e;
        rd(4'd0, d); e = enc(m_s, m_bin);            check(d == e, req, d, e);
        rd(4'd2, d); e = enc(m_m, m_bin);            check(d == e, req, d, e);
        rd(4'd4, d); e = hour_byte(m_h, m_bin, m_h24); check(d == e, req, d, e);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic set_ctrl(bit frz, bit bin, bit h24);
        logic [7:0] d;
        wr(4'd8, {5'd0, h24, bin, frz});
        m_frz = frz; m_bin = bin; m_h24 = h24;
        rd(4'd8, d);
        check(d == {5'd0, h24, bin, frz}, "R7 ctrl readback", d, {5'd0, h24, bin, frz});
    endtask

    task automatic load(int s, int m, int h);
        wr(4'd0, enc(s, m_bin));
        wr(4'd2, enc(m, m_bin));
        wr(4'd4, hour_byte(h, m_bin, m_h24));
        m_s = s; m_m = m; m_h = h;
    endtask

    task automatic model_tick();
        if (!m_frz) begin
            m_s++;
            if (m_s == 60) begin
                m_s = 0; m_m++;
                if (m_m == 60) begin m_m = 0; m_h = (m_h + 1) % 24; end
            end
        end
    endtask

    task automatic do_tick(string req);
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        check(upd_done_o == !m_frz, {req, " R10 done"}, upd_done_o, !m_frz);
        model_tick();
        check_time(req);
        @(negedge clk);
        check(upd_done_o == 1'b0, "R10 done one cycle", upd_done_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(upd_done_o == 1'b0, "R8 done after reset", upd_done_o, 0);
        m_bin = 1; m_h24 = 1;
        check_time("R8 reset time");
        rd(4'd6, d);
        check(d == 8'd0, "R7 unmapped read", d, 0);

        // R1 R2 R3 binary 24h rollover
        set_ctrl(0, 1, 1);
        load(58, 59, 23);
        do_tick("R1 step");
        do_tick("R2 R3 full rollover");
        load(59, 10, 5);
        do_tick("R2 sec carry");

        // R5 BCD
        set_ctrl(0, 0, 1);
        load(9, 59, 19);
        do_tick("R5 bcd units");
        load(59, 59, 9);
        do_tick("R5 bcd hour digit");
        load(59, 59, 23);
        do_tick("R3 bcd 23 to 0");

        // R4 12-hour
        set_ctrl(0, 0, 0);
        load(59, 59, 11);
        do_tick("R4 11am to 12pm");
        rd(4'd4, d);
        check(d == 8'h92, "R4 pm byte", d, 8'h92);
        load(59, 59, 23);
        do_tick("R4 11pm to 12am");
        load(59, 59, 12);
        do_tick("R4 12pm to 1pm");
        set_ctrl(0, 1, 0);
        load(59, 59, 11);
        do_tick("R4 binary 12h");
        rd(4'd4, d);
        check(d == 8'h8C, "R4 binary pm byte", d, 8'h8C);

        // R6 freeze
        set_ctrl(1, 1, 1);
        load(30, 20, 10);
        do_tick("R6 frozen tick");
        do_tick("R6 frozen tick 2");
        set_ctrl(0, 1, 1);
        repeat (2) @(negedge clk);
        check(upd_done_o == 1'b0, "R6 no replay done", upd_done_o, 0);
        check_time("R6 no replay");
        do_tick("R6 resume");

        // R9 write collides with tick
        @(negedge clk);
        tick_i = 1; wr_en_i = 1; addr_i = 4'd2; wdata_i = 8'd44;
        @(negedge clk);
        tick_i = 0; wr_en_i = 0;
        m_m = 44;
        check(upd_done_o == 1'b0, "R9 no done", upd_done_o, 0);
        check_time("R9 write wins");

        // R8 reset keeps control
        set_ctrl(0, 0, 1);
        load(12, 34, 15);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        m_s = 0; m_m = 0; m_h = 0;
        rd(4'd8, d);
        check(d == 8'h04, "R8 ctrl kept", d, 8'h04);
        check_time("R8 time cleared");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(9, 0);
            if (op < 6) begin
                do_tick("R1 R2 random");
            end else if (op < 8) begin
                load($urandom_range(59, 0), $urandom_range(59, 0), $urandom_range(23, 0));
                check_time("R7 random load");
            end else begin
                set_ctrl(($urandom_range(3, 0) == 0), $urandom_range(1, 0), $urandom_range(1, 0));
                load($urandom_range(59, 50), $urandom_range(59, 57), $urandom_range(23, 0));
                check_time("R5 random mode");
            end
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule